// File: doc/BRIEF.md
# Trace Status and Branch Target Nibble Encoder

This block sits beside the retire stage of a small processor and reports its progress to an external trace probe. It uses two 4-bit output ports. The status port carries a code for each cycle: nothing retired, an instruction retired, or a taken branch. It also carries a held code for as long as the core is halted, stopped, entering emulation or processing an exception.

Some taken branches compute their target at run time: returns, jumps or calls through a register, and exception vectors. The core marks these with a variant-addressing flag. For such a branch the block captures the target. One cycle after the branch status, it puts a count marker on the status port. It then sends the target on the data port one nibble per cycle, starting with the least significant nibble.

A configuration input sets the number of bytes sent (two, three or four), or turns the address display off. While a stream is running, a one-entry buffer holds one more target. A target that arrives while the buffer is full is discarded, and a sticky overflow flag is set.

Top module: `trace_status_top`

## Requirements
- R1: While reset is held, and until the first event after it, pstOut and ddataOut are 0x0 and overflowFlag is 0.
- R2: With no mode level active, the status code one cycle after a sampled edge is:
  - 0x5 if retireValid and branchTaken were both high;
  - 0x1 if retireValid was high and branchTaken was low;
  - 0x0 if retireValid was low.
- R3: Mode levels take priority over all other status codes, in this order: haltActive gives 0xF, then stopActive gives 0xE, then emuActive gives 0xD, then excActive gives 0xC. The code is held on every cycle the level stays high.
- R4: A taken branch whose variantAddr is low never produces a marker or any DDATA nibble.
- R5: For a qualifying branch, the cycle after the 0x5 shows a marker: 0x9 when byteSel=1 (2 bytes), 0xA when byteSel=2 (3 bytes), 0xB when byteSel=3 (4 bytes). The first address nibble follows in the next cycle.
- R6: The target is sent as 4, 6 or 8 nibbles on consecutive cycles, address bits [3:0] first and rising by four bits each cycle. DDATA returns to 0x0 in the cycle after the last nibble.
- R7: With byteSel=0, a taken variant branch gives 0x5 only: no marker follows and DDATA stays 0x0.
- R8: A qualifying branch that arrives while an address is pending or streaming is stored in a one-entry buffer. Its own marker and nibbles follow the current stream with no extra gap.
- R9: A qualifying branch that arrives while the buffer is full is dropped and sets overflowFlag. overflowFlag stays set until reset.
- R10: A pending marker waits while any mode level is active, and it is sent in the first cycle after all mode levels are low.
- R11: The marker uses its status-port cycle even if an instruction retires in that cycle, so the retire code for that cycle is not shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rstN | input | 1 | Active-low synchronous reset |
| retireValid | input | 1 | An instruction retired this cycle |
| branchTaken | input | 1 | The retired instruction is a taken change of flow |
| variantAddr | input | 1 | The target is computed at run time (return, indirect jump or call, exception vector) |
| targetAddr | input | ADDR_W | Branch target address |
| byteSel | input | 2 | Address bytes to display: 0 means off, 1 means 2 bytes, 2 means 3 bytes, 3 means 4 bytes |
| excActive | input | 1 | Exception processing in progress |
| emuActive | input | 1 | Emulation-mode entry in progress |
| stopActive | input | 1 | Core stopped |
| haltActive | input | 1 | Core halted |
| pstOut | output | 4 | Processor status code |
| ddataOut | output | 4 | Debug data nibble |
| overflowFlag | output | 1 | Sticky flag: a target was dropped |

## Verification
A wrong nibble counter or a wrong latched byte count shows at the ports within a few cycles of the marker. DDATA ends early or late compared with the marker value, which is visible in the cycle after the expected last nibble. A corrupted buffer-valid bit shows when the first stream ends: either a second marker appears that should not, or an expected one is missing, along with its nibbles. A wrong mode priority shows on pstOut in the cycle after the mode levels change.

// File: rtl/trace_pkg.sv
package trace_pkg;

  localparam logic [3:0] PST_NONE      = 4'h0;
  localparam logic [3:0] PST_SEQ       = 4'h1;
  localparam logic [3:0] PST_BRANCH    = 4'h5;
  localparam logic [3:0] PST_MARK_BASE = 4'h8;
  localparam logic [3:0] PST_EXC       = 4'hC;
  localparam logic [3:0] PST_EMU       = 4'hD;
  localparam logic [3:0] PST_STOP      = 4'hE;
  localparam logic [3:0] PST_HALT      = 4'hF;

  typedef struct packed {
    logic loadNew;   // active address <= targetAddr
    logic loadBuf;   // active address <= buffered address
    logic storeBuf;  // buffered address <= targetAddr
    logic shiftOut;  // emit low nibble of active address, shift right
  } dpCtrl_t;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_MARK   = 2'd1,
    ST_STREAM = 2'd2
  } txState_t;

endpackage

// File: rtl/trace_dp.sv
module trace_dp
  import trace_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           dpCtrl,
  input  logic [ADDR_W-1:0] targetAddr,
  output logic [3:0]        ddataOut
);

  logic [ADDR_W-1:0] actAddr;
  logic [ADDR_W-1:0] bufAddr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      actAddr  <= '0;
      bufAddr  <= '0;
      ddataOut <= '0;
    end else begin
      if (dpCtrl.loadNew)       actAddr <= targetAddr;
      else if (dpCtrl.loadBuf)  actAddr <= bufAddr;
      else if (dpCtrl.shiftOut) actAddr <= actAddr >> 4;

      if (dpCtrl.storeBuf) bufAddr <= targetAddr;

      ddataOut <= dpCtrl.shiftOut ? actAddr[3:0] : 4'h0;
    end
  end

  // R8: the active register is never loaded from both sources in one cycle
  p_single_load_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(dpCtrl.loadNew && dpCtrl.loadBuf));

endmodule

// File: rtl/trace_ctl.sv
module trace_ctl
  import trace_pkg::*;
#(
  parameter int MAX_NIB = 8,
  parameter int CNT_W   = $clog2(MAX_NIB + 1)
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       retireValid,
  input  logic       branchTaken,
  input  logic       variantAddr,
  input  logic [1:0] byteSel,
  input  logic       excActive,
  input  logic       emuActive,
  input  logic       stopActive,
  input  logic       haltActive,
  output dpCtrl_t    dpCtrl,
  output logic [3:0] pstOut,
  output logic       overflowFlag
);

  txState_t   state, stateN;
  logic [CNT_W-1:0] cnt, cntN;
  logic [1:0] actSel, actSelN, bufSel, bufSelN;
  logic       bufValid, bufValidN, ovN;
  logic [3:0] pstN;
  logic       capture, modeBusy, streamDone;

  function automatic logic [CNT_W-1:0] nibCount(input logic [1:0] sel);
    return CNT_W'(2 * (int'(sel) + 1));
  endfunction

  assign capture    = retireValid && branchTaken && variantAddr && (byteSel != 2'd0);
  assign modeBusy   = haltActive || stopActive || emuActive || excActive;
  assign streamDone = (state == ST_STREAM) && (cnt == CNT_W'(1));

  always_comb begin
    stateN    = state;
    cntN      = cnt;
    actSelN   = actSel;
    bufSelN   = bufSel;
    bufValidN = bufValid;
    ovN       = overflowFlag;
    dpCtrl    = '0;

    case (state)
      ST_IDLE: begin
        if (capture) begin
          dpCtrl.loadNew = 1'b1;
          actSelN        = byteSel;
          stateN         = ST_MARK;
        end
      end
      ST_MARK: begin
        if (!modeBusy) begin
          stateN = ST_STREAM;
          cntN   = nibCount(actSel);
        end
      end
      ST_STREAM: begin
        dpCtrl.shiftOut = 1'b1;
        cntN            = cnt - CNT_W'(1);
      end
      default: stateN = ST_IDLE;
    endcase

    if (state != ST_IDLE) begin
      if (streamDone) begin
        if (bufValid) begin
          dpCtrl.loadBuf = 1'b1;
          actSelN        = bufSel;
          stateN         = ST_MARK;
          bufValidN      = capture;
          if (capture) begin
            dpCtrl.storeBuf = 1'b1;
            bufSelN         = byteSel;
          end
        end else if (capture) begin
          dpCtrl.loadNew = 1'b1;
          actSelN        = byteSel;
          stateN         = ST_MARK;
        end else begin
          stateN = ST_IDLE;
        end
      end else if (capture) begin
        if (!bufValid) begin
          dpCtrl.storeBuf = 1'b1;
          bufValidN       = 1'b1;
          bufSelN         = byteSel;
        end else begin
          ovN = 1'b1;
        end
      end
    end
  end

  always_comb begin
    if (haltActive)                             pstN = PST_HALT;
    else if (stopActive)                        pstN = PST_STOP;
    else if (emuActive)                         pstN = PST_EMU;
    else if (excActive)                         pstN = PST_EXC;
    else if (state == ST_MARK)                  pstN = PST_MARK_BASE + {2'b00, actSel};
    else if (retireValid && branchTaken)        pstN = PST_BRANCH;
    else if (retireValid)                       pstN = PST_SEQ;
    else                                        pstN = PST_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state        <= ST_IDLE;
      cnt          <= '0;
      actSel       <= '0;
      bufSel       <= '0;
      bufValid     <= 1'b0;
      overflowFlag <= 1'b0;
      pstOut       <= PST_NONE;
    end else begin
      state        <= stateN;
      cnt          <= cntN;
      actSel       <= actSelN;
      bufSel       <= bufSelN;
      bufValid     <= bufValidN;
      overflowFlag <= ovN;
      pstOut       <= pstN;
    end
  end

  // R3: halt outranks every other source of status
  p_halt_wins_r3: assert property (@(posedge clk) disable iff (!rstN)
    haltActive |=> (pstOut == PST_HALT));

  // R3: stop outranks everything except halt
  p_stop_next_r3: assert property (@(posedge clk) disable iff (!rstN)
    (stopActive && !haltActive) |=> (pstOut == PST_STOP));

  // R5: a marker never shows on two cycles in a row
  p_marker_once_r5: assert property (@(posedge clk) disable iff (!rstN)
    (pstOut[3:2] == 2'b10 && pstOut[1:0] != 2'b00) |=>
    !(pstOut[3:2] == 2'b10 && pstOut[1:0] != 2'b00));

  // R6: the nibble count stays inside the configured window
  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_STREAM) |-> (cnt >= CNT_W'(1) && cnt <= nibCount(actSel)));

  // R9: overflow is sticky
  p_no_overflow_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    overflowFlag |=> overflowFlag);

  // R9: a capture into a full buffer raises the flag
  p_drop_flags_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE && bufValid && capture && !streamDone) |=> overflowFlag);

endmodule

// File: rtl/trace_status_top.sv
module trace_status_top
  import trace_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              retireValid,
  input  logic              branchTaken,
  input  logic              variantAddr,
  input  logic [ADDR_W-1:0] targetAddr,
  input  logic [1:0]        byteSel,
  input  logic              excActive,
  input  logic              emuActive,
  input  logic              stopActive,
  input  logic              haltActive,
  output logic [3:0]        pstOut,
  output logic [3:0]        ddataOut,
  output logic              overflowFlag
);

  localparam int MAX_NIB = ADDR_W / 4;
  localparam int CNT_W   = $clog2(MAX_NIB + 1);

  dpCtrl_t dpCtrl;

  trace_ctl #(.MAX_NIB(MAX_NIB), .CNT_W(CNT_W)) u_ctl (
    .clk          (clk),
    .rstN         (rstN),
    .retireValid  (retireValid),
    .branchTaken  (branchTaken),
    .variantAddr  (variantAddr),
    .byteSel      (byteSel),
    .excActive    (excActive),
    .emuActive    (emuActive),
    .stopActive   (stopActive),
    .haltActive   (haltActive),
    .dpCtrl       (dpCtrl),
    .pstOut       (pstOut),
    .overflowFlag (overflowFlag)
  );

  trace_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .dpCtrl     (dpCtrl),
    .targetAddr (targetAddr),
    .ddataOut   (ddataOut)
  );

  // R4: data is idle one cycle after a direct-branch status while no stream exists
  p_direct_quiet_r4: assert property (@(posedge clk) disable iff (!rstN)
    (u_ctl.state == ST_IDLE && !(retireValid && branchTaken && variantAddr))
    |=> (ddataOut == 4'h0));

endmodule

// File: tb/tb_trace_status_top.sv
`timescale 1ns/1ps
module tb_trace_status_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic        retireValid, branchTaken, variantAddr;
  logic [31:0] targetAddr;
  logic [1:0]  byteSel;
  logic        excActive, emuActive, stopActive, haltActive;
  logic [3:0]  pstOut, ddataOut;
  logic        overflowFlag;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  trace_status_top #(.ADDR_W(32)) dut (
    .clk(clk), .rstN(rstN), .retireValid(retireValid), .branchTaken(branchTaken),
    .variantAddr(variantAddr), .targetAddr(targetAddr), .byteSel(byteSel),
    .excActive(excActive), .emuActive(emuActive), .stopActive(stopActive),
    .haltActive(haltActive), .pstOut(pstOut), .ddataOut(ddataOut),
    .overflowFlag(overflowFlag)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic idleInputs();
    retireValid = 0; branchTaken = 0; variantAddr = 0;
    excActive = 0; emuActive = 0; stopActive = 0; haltActive = 0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 0; idleInputs(); targetAddr = '0; byteSel = 2'd0;
    repeat (2) @(negedge clk);
    chk(pstOut == 4'h0, "R1 pst", pstOut, 0);
    chk(ddataOut == 4'h0, "R1 ddata", ddataOut, 0);
    chk(overflowFlag == 1'b0, "R1 ovf", overflowFlag, 0);
    rstN = 1;
  endtask

  function automatic logic [3:0] nib(input logic [31:0] a, input int i);
    return 4'((a >> (4 * i)) & 32'hF);
  endfunction

  task automatic runBranch(input logic [1:0] sel, input logic [31:0] a);
    int n;
    @(negedge clk);
    retireValid = 1; branchTaken = 1; variantAddr = 1; targetAddr = a; byteSel = sel;
    @(negedge clk);
    idleInputs();
    chk(pstOut == 4'h5, "R2 branch status", pstOut, 5);
    @(negedge clk);
    if (sel != 0) chk(pstOut == 4'h8 + 4'(sel), "R5 marker", pstOut, 8 + sel);
    else          chk(pstOut == 4'h0, "R7 no marker", pstOut, 0);
    chk(ddataOut == 4'h0, "R5 ddata before data", ddataOut, 0);
    n = (sel != 0) ? 2 * (sel + 1) : 8;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (sel != 0) chk(ddataOut == nib(a, i), "R6 nibble", ddataOut, nib(a, i));
      else          chk(ddataOut == 4'h0, "R7 ddata idle", ddataOut, 0);
    end
    @(negedge clk);
    chk(ddataOut == 4'h0, "R6 end of stream", ddataOut, 0);
  endtask

  initial begin
    #(200000 * 5);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] addrs [4];
    logic [3:0]  expPst;
    addrs[0] = 32'h8765_4321;
    addrs[1] = 32'hFEDC_BA98;
    addrs[2] = 32'h0F1E_2D3C;
    addrs[3] = 32'hA5C3_6E19;
    rstN = 0; idleInputs(); targetAddr = '0; byteSel = 0;
    doReset();

    // R2: sequential retire and idle
    @(negedge clk); retireValid = 1;
    @(negedge clk); chk(pstOut == 4'h1, "R2 seq", pstOut, 1); retireValid = 0;
    @(negedge clk); chk(pstOut == 4'h0, "R2 idle", pstOut, 0);

    // R4: direct taken branch, no address ever
    byteSel = 2'd3; targetAddr = 32'h1234_5678;
    retireValid = 1; branchTaken = 1; variantAddr = 0;
    @(negedge clk); idleInputs();
    chk(pstOut == 4'h5, "R2 direct branch", pstOut, 5);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk(pstOut == 4'h0 && ddataOut == 4'h0, "R4 direct quiet", {pstOut, ddataOut}, 0);
    end

    // R5 R6 R7: sweep of widths and addresses
    for (int s = 0; s < 4; s++)
      for (int k = 0; k < 4; k++)
        runBranch(2'(s), addrs[k] ^ (32'h1111_1111 * 32'(s)));

    // R3: every mode combination, held over three cycles
    for (int m = 0; m < 16; m++) begin
      @(negedge clk);
      excActive = m[0]; emuActive = m[1]; stopActive = m[2]; haltActive = m[3];
      expPst = m[3] ? 4'hF : m[2] ? 4'hE : m[1] ? 4'hD : m[0] ? 4'hC : 4'h0;
      for (int c = 0; c < 3; c++) begin
        @(negedge clk);
        chk(pstOut == expPst, "R3 mode priority", pstOut, expPst);
      end
    end
    idleInputs();

    // R10: marker waits behind exception processing
    @(negedge clk);
    retireValid = 1; branchTaken = 1; variantAddr = 1; byteSel = 2'd1; targetAddr = 32'h0000_C3A7;
    @(negedge clk); idleInputs(); excActive = 1;
    chk(pstOut == 4'h5, "R2 branch before exc", pstOut, 5);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk(pstOut == 4'hC && ddataOut == 4'h0, "R10 held by mode", {pstOut, ddataOut}, 8'hC0);
    end
    excActive = 0;
    @(negedge clk); chk(pstOut == 4'h9, "R10 marker after mode", pstOut, 9);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(ddataOut == nib(32'h0000_C3A7, i), "R10 nibble", ddataOut, nib(32'h0000_C3A7, i));
    end
    @(negedge clk); chk(ddataOut == 4'h0, "R6 end", ddataOut, 0);

    // R8 R9 R11: three back-to-back variant branches
    @(negedge clk);
    byteSel = 2'd1; retireValid = 1; branchTaken = 1; variantAddr = 1; targetAddr = 32'h0000_4321;
    @(negedge clk); targetAddr = 32'h0000_9ABC;
    chk(pstOut == 4'h5, "R2 first branch", pstOut, 5);
    @(negedge clk); targetAddr = 32'h0000_7777;
    chk(pstOut == 4'h9, "R11 marker displaces branch", pstOut, 9);
    @(negedge clk); idleInputs();
    chk(overflowFlag == 1'b1, "R9 overflow set", overflowFlag, 1);
    chk(ddataOut == 4'h1, "R6 first stream nib0", ddataOut, 1);
    for (int i = 1; i < 4; i++) begin
      @(negedge clk);
      chk(ddataOut == nib(32'h4321, i), "R6 first stream", ddataOut, nib(32'h4321, i));
    end
    @(negedge clk);
    chk(pstOut == 4'h9 && ddataOut == 4'h0, "R8 queued marker", {pstOut, ddataOut}, 8'h90);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(ddataOut == nib(32'h9ABC, i), "R8 queued nibble", ddataOut, nib(32'h9ABC, i));
    end
    for (int c = 0; c < 10; c++) begin
      @(negedge clk);
      chk(pstOut == 4'h0 && ddataOut == 4'h0, "R9 dropped target silent", {pstOut, ddataOut}, 0);
    end
    chk(overflowFlag == 1'b1, "R9 overflow sticky", overflowFlag, 1);

    doReset();
    @(negedge clk);
    chk(overflowFlag == 1'b0, "R1 overflow cleared", overflowFlag, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule